// File: doc/BRIEF.md
# Receive Byte Queue with Trigger-Level Interrupt

This block sits between a serial receiver and a host bus. Each received character arrives with a one-cycle strobe, the data byte and three error flags: parity, framing and break. The block stores them in a queue of up to 16 entries. The host takes characters from the head with a read pulse. The head byte and its flags are always shown together at the output.

A control write sets four things at once:
- whether the queue is enabled;
- whether the queue is cleared on this write;
- the occupancy threshold for the data-available interrupt (1, 4, 8 or 14);
- how the DMA ready line behaves.

With the queue disabled, the block keeps only one character, like a plain holding register. That is also the state after reset.

When a character arrives and there is no room for it, the character is dropped. A sticky overrun flag then stays set until the host reads status.

Top module: `rxq_top`

## Requirements
- R1: With the queue enabled, up to 16 entries are held and leave in arrival order; `rx_level` gives the occupancy, 0 to 16.
- R2: `rx_byte` and `rx_par_err`, `rx_frm_err`, `rx_brk` show the oldest entry together; `rx_valid` is high whenever `rx_level` is nonzero.
- R3: `cfg_trig` selects the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. `data_avail` is high exactly while `rx_level` is at or above the threshold, so it drops in the same cycle that occupancy falls below it.
- R4: After reset the queue is disabled, the threshold code is 00 and DMA mode is 0; `rx_level`, `data_avail`, `dma_rdy` and `overrun` are 0.
- R5: While the queue is disabled, one entry is held and the threshold is 1. A second byte arriving before the read is discarded and sets `overrun`.
- R6: A byte arriving with no free slot (and no pop in the same cycle) is discarded and sets `overrun`. `stat_rd` clears the flag, but a new overrun in the same cycle wins.
- R7: A control write with `cfg_clr`=1 empties the queue at that edge. The bit is not stored, and a byte arriving in the same cycle is dropped without setting `overrun`.
- R8: A control write that changes `cfg_fifo_en` empties the queue.
- R9: In DMA mode 0 (`cfg_dma`=0), or while the queue is disabled, `dma_rdy` equals `rx_level != 0`.
- R10: In DMA mode 1 with the queue enabled, `dma_rdy` rises when occupancy reaches the threshold. It then stays high until occupancy is 0.
- R11: A push and a pop in the same cycle on a full queue are both accepted, and `rx_level` stays the same.
- R12: A read pulse on an empty queue changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | Received-character strobe |
| in_byte | input | 8 | Received character |
| in_par_err | input | 1 | Parity error of this character |
| in_frm_err | input | 1 | Framing error of this character |
| in_brk | input | 1 | Break seen on this character |
| rd_en | input | 1 | Host pop of the head entry |
| stat_rd | input | 1 | Host status read, clears overrun |
| cfg_wr | input | 1 | Control write strobe |
| cfg_fifo_en | input | 1 | Queue enable |
| cfg_clr | input | 1 | Empty the queue (not stored) |
| cfg_trig | input | 2 | Threshold select |
| cfg_dma | input | 1 | DMA ready mode |
| rx_byte | output | 8 | Head character |
| rx_par_err | output | 1 | Head parity flag |
| rx_frm_err | output | 1 | Head framing flag |
| rx_brk | output | 1 | Head break flag |
| rx_valid | output | 1 | Queue not empty |
| rx_level | output | 5 | Occupancy |
| overrun | output | 1 | Sticky overrun flag |
| data_avail | output | 1 | Threshold interrupt |
| dma_rdy | output | 1 | DMA ready |

## Verification
The queue state is updated by registers at the edge where a strobe, read or control write is taken. The outputs follow from that state with no further register stage, so `rx_level`, the head entry, `overrun`, `data_avail` and `dma_rdy` are all due one edge after the stimulus. The bench applies each stimulus, waits for exactly one rising edge plus 2 ns, and compares every output there. The strobe is then released before the next edge. Reset release passes through a two-stage synchronizer, so the bench waits several cycles after release before driving anything.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  parameter int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_fifo_en,
  input  logic             cfg_clr,
  input  logic [1:0]       cfg_trig,
  input  logic             cfg_dma,
  output logic             fifo_en_q,
  output logic             dma_q,
  output logic             flush,
  output logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] cap
);
  logic       en_d;
  logic       dma_d;
  logic [1:0] trig_q;
  logic [1:0] trig_d;
  logic [CNT_W-1:0] lvl_sel;

  // next-state
  always_comb begin
    en_d   = fifo_en_q;
    dma_d  = dma_q;
    trig_d = trig_q;
    if (cfg_wr) begin
      en_d   = cfg_fifo_en;
      dma_d  = cfg_dma;
      trig_d = cfg_trig;
    end
  end

  // clear request, or a change of mode, empties the queue
  assign flush = cfg_wr && (cfg_clr || (cfg_fifo_en != fifo_en_q));

  always_comb begin
    case (trig_q)
      2'b00:   lvl_sel = CNT_W'(LVL0);
      2'b01:   lvl_sel = CNT_W'(LVL1);
      2'b10:   lvl_sel = CNT_W'(LVL2);
      default: lvl_sel = CNT_W'(LVL3);
    endcase
  end

  assign thr = fifo_en_q ? lvl_sel : CNT_W'(1);
  assign cap = fifo_en_q ? CNT_W'(DEPTH) : CNT_W'(1);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_q <= 1'b0;
      dma_q     <= 1'b0;
      trig_q    <= 2'b00;
    end else if (cfg_wr) begin
      fifo_en_q <= en_d;
      dma_q     <= dma_d;
      trig_q    <= trig_d;
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  rxq_entry_t       push_entry,
  input  logic             pop_req,
  input  logic             flush,
  input  logic             stat_rd,
  input  logic [CNT_W-1:0] cap,
  output rxq_entry_t       head,
  output logic [CNT_W-1:0] count,
  output logic             ovr_q
);
  rxq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_d, rd_ptr_d;
  logic [CNT_W-1:0] count_d;
  logic             full, push, pop, ovr_set, ovr_d;
  logic [DEPTH-1:0] slot_we;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // next-state
  always_comb begin
    full    = (count >= cap);
    pop     = pop_req && (count != '0) && !flush;
    push    = push_req && !flush && (!full || pop);
    ovr_set = push_req && !flush && full && !pop;
    ovr_d   = ovr_set ? 1'b1 : (stat_rd ? 1'b0 : ovr_q);
    if (flush) begin
      count_d  = '0;
      wr_ptr_d = '0;
      rd_ptr_d = '0;
    end else begin
      count_d  = count + CNT_W'(push) - CNT_W'(pop);
      wr_ptr_d = push ? ptr_inc(wr_ptr) : wr_ptr;
      rd_ptr_d = pop  ? ptr_inc(rd_ptr) : rd_ptr;
    end
    slot_we = '0;
    if (push) slot_we[wr_ptr] = 1'b1;
  end

  // storage: one enabled register per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (slot_we[i]) mem[i] <= push_entry;
    end
  end

  assign head = mem[rd_ptr];

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      ovr_q  <= 1'b0;
    end else begin
      count  <= count_d;
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      ovr_q  <= ovr_d;
    end
  end
endmodule

// File: rtl/rxq_notify.sv
module rxq_notify #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] thr,
  input  logic             fifo_en_q,
  input  logic             dma_q,
  output logic             data_avail,
  output logic             dma_rdy
);
  logic burst_q, burst_d, burst_mode, at_thr, burst_val;

  // next-state
  always_comb begin
    at_thr     = (count >= thr);
    burst_mode = fifo_en_q && dma_q;
    burst_val  = at_thr || (burst_q && (count != '0));
    burst_d    = burst_mode ? burst_val : 1'b0;
  end

  assign data_avail = at_thr;
  assign dma_rdy    = burst_mode ? burst_val : (count != '0);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_q <= 1'b0;
    else        burst_q <= burst_d;
  end
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_par_err,
  input  logic              in_frm_err,
  input  logic              in_brk,
  input  logic              rd_en,
  input  logic              stat_rd,
  input  logic              cfg_wr,
  input  logic              cfg_fifo_en,
  input  logic              cfg_clr,
  input  logic [1:0]        cfg_trig,
  input  logic              cfg_dma,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_par_err,
  output logic              rx_frm_err,
  output logic              rx_brk,
  output logic              rx_valid,
  output logic [CNT_W-1:0]  rx_level,
  output logic              overrun,
  output logic              data_avail,
  output logic              dma_rdy
);
  logic [1:0]       rst_sync;
  logic             rst_s_n;
  logic             fifo_en_q, dma_q, flush;
  logic [CNT_W-1:0] thr, cap, count;
  rxq_entry_t       in_entry, head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  assign in_entry = '{brk: in_brk, frm: in_frm_err, par: in_par_err, data: in_byte};

  rxq_ctrl #(
    .DEPTH(DEPTH), .CNT_W(CNT_W),
    .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_s_n),
    .cfg_wr(cfg_wr), .cfg_fifo_en(cfg_fifo_en), .cfg_clr(cfg_clr),
    .cfg_trig(cfg_trig), .cfg_dma(cfg_dma),
    .fifo_en_q(fifo_en_q), .dma_q(dma_q), .flush(flush),
    .thr(thr), .cap(cap)
  );

  rxq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_s_n),
    .push_req(in_vld), .push_entry(in_entry),
    .pop_req(rd_en), .flush(flush), .stat_rd(stat_rd), .cap(cap),
    .head(head), .count(count), .ovr_q(overrun)
  );

  rxq_notify #(.CNT_W(CNT_W)) u_notify (
    .clk(clk), .rst_n(rst_s_n),
    .count(count), .thr(thr), .fifo_en_q(fifo_en_q), .dma_q(dma_q),
    .data_avail(data_avail), .dma_rdy(dma_rdy)
  );

  assign rx_byte    = head.data;
  assign rx_par_err = head.par;
  assign rx_frm_err = head.frm;
  assign rx_brk     = head.brk;
  assign rx_valid   = (count != '0);
  assign rx_level   = count;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic             in_vld,
  input logic             rd_en,
  input logic             cfg_wr,
  input logic             cfg_clr,
  input logic [CNT_W-1:0] level,
  input logic [CNT_W-1:0] thr,
  input logic             fifo_en_q,
  input logic             dma_q,
  input logic             overrun,
  input logic             data_avail,
  input logic             dma_rdy
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    level <= FULL);

  p_avail_drops_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (data_avail && rd_en && !in_vld && !cfg_wr && level == thr) |=> !data_avail);

  p_single_hold_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !fifo_en_q |-> level <= CNT_W'(1));

  p_drop_full_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_vld && level == FULL && !rd_en && !cfg_wr) |=> (overrun && level == FULL));

  p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_wr && cfg_clr) |=> level == '0);

  p_dma_single_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!dma_q || !fifo_en_q) |-> (dma_rdy == (level != '0)));

  p_dma_burst_hold_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fifo_en_q && dma_q && dma_rdy && !cfg_wr) |=> (level == '0 || dma_rdy));

  p_full_swap_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fifo_en_q && level == FULL && in_vld && rd_en && !cfg_wr) |=> level == FULL);

  p_empty_pop_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    (level == '0 && rd_en && !in_vld && !cfg_wr) |=> level == '0);
endmodule

bind rxq_top rxq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq_checker (
  .clk(clk), .rst_s_n(rst_s_n), .in_vld(in_vld), .rd_en(rd_en),
  .cfg_wr(cfg_wr), .cfg_clr(cfg_clr), .level(rx_level), .thr(thr),
  .fifo_en_q(fifo_en_q), .dma_q(dma_q), .overrun(overrun),
  .data_avail(data_avail), .dma_rdy(dma_rdy)
);

// File: tb/rxq_top_bench.sv
module rxq_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_vld, in_par_err, in_frm_err, in_brk, rd_en, stat_rd;
  logic       cfg_wr, cfg_fifo_en, cfg_clr, cfg_dma;
  logic [1:0] cfg_trig;
  logic [7:0] in_byte, rx_byte;
  logic       rx_par_err, rx_frm_err, rx_brk, rx_valid, overrun, data_avail, dma_rdy;
  logic [4:0] rx_level;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  rxq_top u_rxq_top (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
    .in_par_err(in_par_err), .in_frm_err(in_frm_err), .in_brk(in_brk),
    .rd_en(rd_en), .stat_rd(stat_rd), .cfg_wr(cfg_wr), .cfg_fifo_en(cfg_fifo_en),
    .cfg_clr(cfg_clr), .cfg_trig(cfg_trig), .cfg_dma(cfg_dma),
    .rx_byte(rx_byte), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
    .rx_brk(rx_brk), .rx_valid(rx_valid), .rx_level(rx_level), .overrun(overrun),
    .data_avail(data_avail), .dma_rdy(dma_rdy)
  );

  // {vld, data, rd, exp_level, exp_avail, exp_dma, check_head, exp_head}
  localparam logic [25:0] VEC [0:10] = '{
    {1'b1, 8'h11, 1'b0, 5'd1, 1'b0, 1'b0, 1'b1, 8'h11},
    {1'b1, 8'h22, 1'b0, 5'd2, 1'b0, 1'b0, 1'b1, 8'h11},
    {1'b1, 8'h33, 1'b0, 5'd3, 1'b0, 1'b0, 1'b1, 8'h11},
    {1'b1, 8'h44, 1'b0, 5'd4, 1'b1, 1'b1, 1'b1, 8'h11},
    {1'b1, 8'h55, 1'b1, 5'd4, 1'b1, 1'b1, 1'b1, 8'h22},
    {1'b0, 8'h00, 1'b1, 5'd3, 1'b0, 1'b1, 1'b1, 8'h33},
    {1'b0, 8'h00, 1'b1, 5'd2, 1'b0, 1'b1, 1'b1, 8'h44},
    {1'b0, 8'h00, 1'b1, 5'd1, 1'b0, 1'b1, 1'b1, 8'h55},
    {1'b0, 8'h00, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'h66, 1'b0, 5'd1, 1'b0, 1'b0, 1'b1, 8'h66}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2: flags follow the byte: par=bit0, frm=bit1, brk=bit2
  task automatic chk_head(input logic [7:0] exp, input string tag);
    chk(rx_valid && rx_byte == exp && {rx_brk, rx_frm_err, rx_par_err} == exp[2:0],
        tag, {rx_brk, rx_frm_err, rx_par_err, rx_byte}, {exp[2:0], exp});
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic op(input logic v, input logic [7:0] d, input logic r, input logic s);
    in_vld = v; in_byte = d; in_par_err = d[0]; in_frm_err = d[1]; in_brk = d[2];
    rd_en = r; stat_rd = s;
    cyc();
    in_vld = 1'b0; rd_en = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic cfg(input logic en, input logic clr, input logic [1:0] trig, input logic dm);
    cfg_wr = 1'b1; cfg_fifo_en = en; cfg_clr = clr; cfg_trig = trig; cfg_dma = dm;
    cyc();
    cfg_wr = 1'b0; cfg_clr = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_vld = 0; in_byte = 0; in_par_err = 0; in_frm_err = 0; in_brk = 0;
    rd_en = 0; stat_rd = 0; cfg_wr = 0; cfg_fifo_en = 0; cfg_clr = 0;
    cfg_trig = 0; cfg_dma = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R4 reset state
    chk(rx_level == 0 && !rx_valid, "R4 level", rx_level, 0);
    chk(!data_avail && !dma_rdy && !overrun, "R4 flags",
        {data_avail, dma_rdy, overrun}, 0);

    // R5 single holding register after reset, threshold 1, DMA mode 0 (R9)
    op(1, 8'h81, 0, 0);
    chk(rx_level == 1 && data_avail, "R5 hold one, threshold 1", {rx_level, data_avail}, {5'd1, 1'b1});
    chk(dma_rdy, "R9 mode0 ready", dma_rdy, 1);
    op(1, 8'h82, 0, 0);
    chk(rx_level == 1 && overrun, "R5 second byte dropped", {rx_level, overrun}, {5'd1, 1'b1});
    chk_head(8'h81, "R5 head kept");
    op(0, 8'h00, 0, 1);
    chk(!overrun, "R6 status read clears", overrun, 0);
    op(0, 8'h00, 1, 0);
    chk(rx_level == 0 && !data_avail && !dma_rdy, "R9 empty not ready",
        {rx_level, data_avail, dma_rdy}, 0);

    // R8 mode change empties
    op(1, 8'h90, 0, 0);
    cfg(1, 0, 2'b01, 1);
    chk(rx_level == 0 && !rx_valid, "R8 enable empties", rx_level, 0);

    // table: threshold 4, DMA mode 1 (R1 R2 R3 R10 R11-style swap R12)
    for (int i = 0; i < 11; i++) begin
      op(VEC[i][25], VEC[i][24:17], VEC[i][16], 1'b0);
      chk(rx_level == VEC[i][15:11], $sformatf("R1 level step %0d", i), rx_level, VEC[i][15:11]);
      chk(data_avail == VEC[i][10], $sformatf("R3 avail step %0d", i), data_avail, VEC[i][10]);
      chk(dma_rdy == VEC[i][9], $sformatf("R10 dma step %0d", i), dma_rdy, VEC[i][9]);
      if (VEC[i][8]) chk_head(VEC[i][7:0], $sformatf("R2 head step %0d", i));
      else chk(!rx_valid, $sformatf("R12 empty step %0d", i), rx_valid, 0);
    end

    // R3 threshold 8 and 14, R7 clear, mode 0
    cfg(1, 1, 2'b10, 0);
    chk(rx_level == 0, "R7 clear", rx_level, 0);
    for (int k = 0; k < 7; k++) op(1, 8'h40 + 8'(k), 0, 0);
    chk(rx_level == 7 && !data_avail, "R3 below 8", {rx_level, data_avail}, {5'd7, 1'b0});
    chk(dma_rdy, "R9 mode0 ready nonempty", dma_rdy, 1);
    op(1, 8'h47, 0, 0);
    chk(data_avail, "R3 at 8", data_avail, 1);
    cfg(1, 0, 2'b11, 0);
    chk(rx_level == 8 && !data_avail, "R3 threshold 14 kept data", {rx_level, data_avail}, {5'd8, 1'b0});
    for (int k = 8; k < 13; k++) op(1, 8'h40 + 8'(k), 0, 0);
    chk(rx_level == 13 && !data_avail, "R3 at 13", {rx_level, data_avail}, {5'd13, 1'b0});
    op(1, 8'h4D, 0, 0);
    chk(data_avail, "R3 at 14", data_avail, 1);
    op(1, 8'h4E, 0, 0);
    op(1, 8'h4F, 0, 0);
    chk(rx_level == 16 && !overrun, "R1 full", {rx_level, overrun}, {5'd16, 1'b0});
    op(1, 8'hEE, 0, 0);
    chk(rx_level == 16 && overrun, "R6 drop when full", {rx_level, overrun}, {5'd16, 1'b1});
    chk_head(8'h40, "R6 head unchanged");
    op(0, 8'h00, 0, 1);
    chk(!overrun, "R6 cleared", overrun, 0);
    op(1, 8'hE0, 1, 0);
    chk(rx_level == 16 && !overrun, "R11 swap at full", {rx_level, overrun}, {5'd16, 1'b0});
    chk_head(8'h41, "R11 head advanced");
    op(1, 8'hE1, 0, 1);
    chk(overrun && rx_level == 16, "R6 set wins over clear", overrun, 1);
    for (int k = 0; k < 16; k++) begin
      chk_head((k < 15) ? 8'h41 + 8'(k) : 8'hE0, $sformatf("R1 order %0d", k));
      op(0, 8'h00, 1, 0);
    end
    chk(rx_level == 0 && !data_avail && !dma_rdy, "R1 drained",
        {rx_level, data_avail, dma_rdy}, 0);

    // R7 clear with simultaneous byte
    op(0, 8'h00, 0, 1);
    op(1, 8'h01, 0, 0);
    op(1, 8'h02, 0, 0);
    op(1, 8'h03, 0, 0);
    in_vld = 1'b1; in_byte = 8'h77;
    cfg(1, 1, 2'b11, 0);
    in_vld = 1'b0;
    chk(rx_level == 0 && !overrun, "R7 clear drops byte quietly", {rx_level, overrun}, 0);
    op(1, 8'h05, 0, 0);
    chk(rx_level == 1 && !data_avail, "R7 clear bit not held, threshold kept", {rx_level, data_avail}, {5'd1, 1'b0});

    summary();
    $finish;
  end
endmodule